// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This block connects a simple request port to an asynchronous dynamic memory whose row and column addresses share a single address bus. A request carries a flat word address. The upper bits form the row and the lower bits form the column. The controller puts the row on the bus, drops the row strobe, switches the bus to the column, and drops the column strobe. For a read it enables the device output and captures the returned word. For a write it drives the data and the write-enable before the column strobe falls.

The cells lose their charge, so a free-running timer raises a refresh request at a fixed interval. At the next idle point the controller runs a cycle that asserts only the row strobe, using the row held in a refresh counter. The counter then moves on to the next row and returns to zero after the last row. A pending refresh beats any waiting request, but it never cuts into an access that has already started. Both strobes are active low and rest high for at least one precharge state between cycles.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, the strobe, output-enable and write-enable outputs are all high (inactive), the data bus is not driven, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: The row is `req_addr_i[ROW_W+COL_W-1:COL_W]` and the column is `req_addr_i[COL_W-1:0]`. The row is on `dram_addr_o` when the row strobe falls. The column is on `dram_addr_o` when the column strobe falls, at least one cycle later. The column strobe is never low while the row strobe is high.
- R3: During a read, output-enable is low and the controller does not drive the data bus. `rsp_valid_o` pulses for one cycle exactly `CAS_CYC+3` cycles after the accepting edge, and it carries the word most recently written to that address.
- R4: During a write, write-enable is low and the write data is driven from at least one cycle before the column strobe falls. The stored word is read back unchanged.
- R5: After each cycle, both strobes stay high for at least one cycle before the row strobe falls again.
- R6: A refresh is requested every `REF_PERIOD` clocks. It is a row-strobe-only cycle in which the column strobe stays high and the refresh row is on `dram_addr_o`. With no requests pending, successive refreshes start exactly `REF_PERIOD` cycles apart.
- R7: The refresh row starts at 0 after reset. It increases by one after each refresh and returns to 0 after `ROWS-1`.
- R8: A pending refresh is taken before a waiting request. Under requests that never stop, refreshes still occur at the timer rate.
- R9: A request is accepted only on an edge where `req_ready_o` is 1. `req_ready_o` is 0 from acceptance until the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request accepted on this edge if valid |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_dq_o | output | DATA_W | Data driven toward the memory |
| dram_dq_oe_o | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | DATA_W | Data returned by the memory |

## Verification
The bench builds the controller with 3 row bits and 3 column bits, 8-bit data, `ROWS=6` and `REF_PERIOD=40`. A refresh period of 40 clocks lets one run include well over six refreshes. That is enough to see the row counter wrap at a count that is not a power of two, and to see refreshes fall between back-to-back accesses. The 64-word space also lets the behavioural memory check the strobe order at every address corner.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_AROW,
    ST_ARAS,
    ST_ACOL,
    ST_ACAS,
    ST_RROW,
    ST_RRAS,
    ST_PRE
  } seq_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int unsigned REF_PERIOD = 780,
  parameter int unsigned ROWS       = 256,
  parameter int unsigned ROW_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned TW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

  logic [TW-1:0] tick_q;
  logic          fire;

  assign fire = (tick_q == TW'(REF_PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      pend_o <= 1'b0;
    end else begin
      tick_q <= fire ? '0 : tick_q + 1'b1;
      if (fire)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end

  // row wraps at ROWS, which need not be a power of two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (ack_i) row_o <= (row_o == ROW_W'(ROWS - 1)) ? '0 : row_o + 1'b1;
  end

  assert_row_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(row_o) < ROWS);
  assert_ack_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> pend_o);
  assert_row_steps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(row_o));
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned COL_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RAS_CYC = 2,
  parameter int unsigned CAS_CYC = 2,
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  input  logic              ref_pend_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic              ref_ack_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_oe_no,
  output logic              dram_we_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam int unsigned MAX_CYC = (RAS_CYC > CAS_CYC) ? RAS_CYC : CAS_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  wait_q, wait_d;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              take_ref, take_req, col_phase, last_cas;

  assign take_ref  = (state_q == ST_IDLE) && ref_pend_i;
  assign take_req  = (state_q == ST_IDLE) && !ref_pend_i && req_valid_i;
  assign col_phase = (state_q == ST_ACOL) || (state_q == ST_ACAS);
  assign last_cas  = (state_q == ST_ACAS) && (wait_q == '0);

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    unique case (state_q)
      ST_IDLE: if (take_ref) state_d = ST_RROW;
               else if (take_req) state_d = ST_AROW;
      ST_AROW: state_d = ST_ARAS;
      ST_ARAS: state_d = ST_ACOL;
      ST_ACOL: begin
        state_d = ST_ACAS;
        wait_d  = CNT_W'(CAS_CYC - 1);
      end
      ST_ACAS: if (wait_q == '0) state_d = ST_PRE;
               else wait_d = wait_q - 1'b1;
      ST_RROW: begin
        state_d = ST_RRAS;
        wait_d  = CNT_W'(RAS_CYC - 1);
      end
      ST_RRAS: if (wait_q == '0) state_d = ST_PRE;
               else wait_d = wait_q - 1'b1;
      ST_PRE:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wait_q      <= '0;
      row_q       <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q     <= state_d;
      wait_q      <= wait_d;
      rsp_valid_o <= last_cas && !we_q;
      if (last_cas && !we_q) rsp_rdata_o <= dram_dq_i;
      if (take_ref) begin
        row_q <= ref_row_i;
        we_q  <= 1'b0;
      end else if (take_req) begin
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign ref_ack_o    = take_ref;
  assign req_ready_o  = (state_q == ST_IDLE) && !ref_pend_i;
  assign dram_ras_no  = !((state_q == ST_ARAS) || col_phase || (state_q == ST_RRAS));
  assign dram_cas_no  = (state_q != ST_ACAS);
  assign dram_addr_o  = col_phase ? ADDR_W'(col_q) : ADDR_W'(row_q);
  assign dram_oe_no   = !(col_phase && !we_q);
  assign dram_we_no   = !(col_phase && we_q);
  assign dram_dq_oe_o = col_phase && we_q;
  assign dram_dq_o    = wdata_q;

  assert_cas_under_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  assert_ras_before_cas_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> $past(!dram_ras_no));
  assert_read_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> !dram_dq_oe_o);
  assert_rsp_after_cas_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!dram_cas_no));
  assert_data_before_cas_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_we_no) |-> $past(dram_dq_oe_o));
  assert_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |-> (dram_cas_no ##1 dram_ras_no));
  assert_refresh_ras_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o |=> (dram_cas_no ##1 dram_cas_no));
  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (dram_ras_no && dram_cas_no && dram_oe_no && dram_we_no));
  assert_ref_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pend_i && (state_q == ST_IDLE)) |-> !req_ready_o);
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int unsigned ROW_W      = 8,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ROWS       = 256,
  parameter int unsigned REF_PERIOD = 780,
  parameter int unsigned RAS_CYC    = 2,
  parameter int unsigned CAS_CYC    = 2,
  localparam int unsigned ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int unsigned REQ_W     = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [REQ_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_oe_no,
  output logic              dram_we_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  logic             ref_pend, ref_ack;
  logic [ROW_W-1:0] ref_row;

  dram_refresh_timer #(
    .REF_PERIOD(REF_PERIOD),
    .ROWS      (ROWS),
    .ROW_W     (ROW_W)
  ) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ref_ack),
    .pend_o(ref_pend),
    .row_o (ref_row)
  );

  dram_seq #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .RAS_CYC(RAS_CYC),
    .CAS_CYC(CAS_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_row_i   (req_addr_i[REQ_W-1:COL_W]),
    .req_col_i   (req_addr_i[COL_W-1:0]),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .ref_pend_i  (ref_pend),
    .ref_row_i   (ref_row),
    .ref_ack_o   (ref_ack),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .dram_addr_o (dram_addr_o),
    .dram_ras_no (dram_ras_no),
    .dram_cas_no (dram_cas_no),
    .dram_oe_no  (dram_oe_no),
    .dram_we_no  (dram_we_no),
    .dram_dq_o   (dram_dq_o),
    .dram_dq_oe_o(dram_dq_oe_o),
    .dram_dq_i   (dram_dq_i)
  );
endmodule

// File: tb/dram_ctrl_test.sv
`timescale 1ns/1ps
module dram_ctrl_test;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 8, ROWS = 6, REF_PERIOD = 40;
  localparam int CAS_CYC = 2, RAS_CYC = 2;
  localparam int LAT = CAS_CYC + 3;

  typedef struct packed {
    logic       we;
    logic [5:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'h00, 8'h11}, '{1'b1, 6'h07, 8'h22}, '{1'b1, 6'h38, 8'h33},
    '{1'b1, 6'h3F, 8'hA5}, '{1'b0, 6'h00, 8'h00}, '{1'b0, 6'h07, 8'h00},
    '{1'b0, 6'h38, 8'h00}, '{1'b0, 6'h3F, 8'h00}, '{1'b1, 6'h07, 8'h5A},
    '{1'b0, 6'h07, 8'h00}, '{1'b0, 6'h15, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata, dq_o, dq_i;
  logic [2:0] dram_addr;
  logic ras_n, cas_n, oe_n, we_n, dq_oe;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] exp_mem [64];
  logic [7:0] mem [64];
  logic [2:0] lat_row = '0, lat_col = '0;
  int ref_n = 0, viol = 0;
  int ref_rows [64];
  int ref_cyc  [64];
  int ras_fall_cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ROWS(ROWS),
              .REF_PERIOD(REF_PERIOD), .RAS_CYC(RAS_CYC), .CAS_CYC(CAS_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .dram_addr_o(dram_addr),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_oe_no(oe_n), .dram_we_no(we_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural memory: latches row/col on strobe falls, flags ordering faults
  assign dq_i = (!cas_n && !oe_n) ? mem[{lat_row, lat_col}] : '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_dqoe = 1'b0, saw_cas = 1'b0;
  int both_high = 2;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (!cas_n) begin viol++; $display("FAIL R2: cas low at ras fall, actual 0 expected 1"); end
        if (both_high < 1) begin viol++; $display("FAIL R5: precharge %0d expected >=1", both_high); end
        lat_row = dram_addr; saw_cas = 1'b0; ras_fall_cyc = cyc;
      end
      if (p_cas && !cas_n) begin
        if (ras_n || p_ras) begin viol++; $display("FAIL R2: ras not low before cas, actual 1 expected 0"); end
        lat_col = dram_addr; saw_cas = 1'b1;
        if (!we_n) begin
          if (!p_dqoe) begin viol++; $display("FAIL R4: data not driven before cas, actual 0 expected 1"); end
          mem[{lat_row, dram_addr}] = dq_o;
        end
      end
      if (!p_ras && ras_n && !saw_cas && ref_n < 64) begin
        ref_rows[ref_n] = lat_row; ref_cyc[ref_n] = ras_fall_cyc; ref_n++;
      end
      if (!oe_n && dq_oe) begin viol++; $display("FAIL R3: bus driven during read, actual 1 expected 0"); end
      both_high = (ras_n && cas_n) ? both_high + 1 : 0;
    end
    p_ras = ras_n; p_cas = cas_n; p_dqoe = dq_oe;
  end

  task automatic access(input logic we, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
    if (we) begin
      exp_mem[a] = d;
      while (!req_ready) @(negedge clk);
    end else begin
      for (int k = 1; k < LAT; k++) begin
        @(negedge clk);
        if (rsp_valid) chk(1'b0, "R3 early rsp", k, LAT);
      end
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R3 rsp latency", rsp_valid, 1);
      chk(rsp_rdata == exp_mem[a], "R3/R4 read data", rsp_rdata, exp_mem[a]);
    end
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, c0, r0, span;
    for (int i = 0; i < 64; i++) begin exp_mem[i] = '0; mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ras_n && cas_n && oe_n && we_n && !dq_oe && !rsp_valid, "R1 reset pins",
        {ras_n, cas_n, oe_n, we_n, dq_oe, rsp_valid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(ras_n && cas_n && !dq_oe, "R1 idle strobes", {ras_n, cas_n, dq_oe}, 3'b110);

    // R2, R3, R4 table walk
    for (int i = 0; i < NV; i++) access(VEC[i].we, VEC[i].addr, VEC[i].data);
    // R2 corner: same row, adjacent columns
    access(1'b1, 6'h28, 8'hC3);
    access(1'b1, 6'h29, 8'h3C);
    access(1'b0, 6'h28, 8'h00);
    access(1'b0, 6'h29, 8'h00);

    // R6: idle spacing between refreshes
    base = ref_n;
    repeat (3 * REF_PERIOD + 5) @(negedge clk);
    chk(ref_n - base >= 2, "R6 refreshes while idle", ref_n - base, 2);
    if (ref_n - base >= 2)
      chk(ref_cyc[ref_n-1] - ref_cyc[ref_n-2] == REF_PERIOD, "R6 refresh spacing",
          ref_cyc[ref_n-1] - ref_cyc[ref_n-2], REF_PERIOD);

    // R8: refresh keeps its rate under back-to-back requests
    c0 = cyc; r0 = ref_n;
    for (int i = 0; i < 30; i++) access(1'b0, 6'h3F, 8'h00);
    span = cyc - c0;
    chk(ref_n - r0 >= span / REF_PERIOD - 1, "R8 refreshes under load", ref_n - r0,
        span / REF_PERIOD - 1);

    // R7: refresh row order and wrap
    chk(ref_n > ROWS, "R7 enough refreshes", ref_n, ROWS + 1);
    for (int i = 0; i < ref_n; i++)
      chk(ref_rows[i] == i % ROWS, "R7 refresh row", ref_rows[i], i % ROWS);

    chk(viol == 0, "R2/R5 strobe violations", viol, 0);

    // R1: reset in the middle of an access
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 6'h12;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ras_n && cas_n && oe_n && we_n && !dq_oe, "R1 reset mid-access",
        {ras_n, cas_n, oe_n, we_n, dq_oe}, 5'b11110);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 ready after second reset", {req_ready, rsp_valid}, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule